// File: doc/BRIEF.md
# Video Capture Start Sequencer

This block decides when a video capture begins and how many fields or frames it passes. Software can start it directly. It can also be armed to wait for an edge on one of several trigger lines. Each line has its own enable and its own choice of edge. Once the start event is taken, the block can skip a programmed number of fields. It can then hold off until a field of the wanted parity arrives, when running in frame mode on interlaced video. After that it raises a capture enable for an exact number of fields, or for an exact number of frames of two fields each, and stops.

The capture enable only switches at field boundaries, so downstream logic never sees a partial field. Status outputs report whether a sequence is in progress, whether it has finished, and how many units have been captured so far. A software abort returns the block to idle from any state.

Top module: `vid_start_ctrl`

## Requirements
- R1: After reset, `cap_en`, `busy` and `done` are 0 and `cap_count` is 0.
- R2: A one-cycle `sw_start` while idle or done begins a sequence. With `cfg_delay` = 0 and no alignment, `cap_en` is 1 from the cycle after the next `field_start`.
- R3: The block captures `cfg_count` fields when `cfg_frame_mode` = 0, and 2×`cfg_count` fields when `cfg_frame_mode` = 1. A `cfg_count` of 0 acts as 1. At the end, `cap_count` equals the effective count, in fields or frames.
- R4: After a one-cycle `sw_arm`, the block waits with `cap_en` = 0. Only an edge on a trigger line whose `cfg_trig_en` bit is 1 starts the sequence. Lines whose bit is 0 have no effect.
- R5: A `cfg_trig_fall` bit of 1 makes its line start on a high-to-low transition. A bit of 0 makes it start on a low-to-high transition.
- R6: After the start event, the first `cfg_delay` field strobes are skipped. Capture begins on the next qualifying field after that.
- R7: When `cfg_frame_mode` = 1 and `cfg_align_en` = 1, the first captured field has `field_odd` equal to `cfg_align_odd`. In field mode the alignment setting has no effect.
- R8: `sw_start` and trigger edges that arrive while a sequence is running do not restart it or change its length.
- R9: `cap_en` changes only in the cycle after a `field_start` strobe, or after an abort.
- R10: A one-cycle `sw_abort` in any state leaves `busy`, `done`, `cap_en` and `cap_count` at 0 on the next cycle. The block is then idle, and trigger edges are ignored.
- R11: `busy` is 1 from arm or start until the last field ends. `done` is 1 from then until the next start, arm or abort. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| field_odd | input | 1 | Parity of the field starting, valid with `field_start` |
| trig_in | input | NTRIG | Asynchronous trigger lines |
| cfg_trig_en | input | NTRIG | Per-line trigger enable |
| cfg_trig_fall | input | NTRIG | Per-line edge select, 1 = falling |
| cfg_delay | input | DLY_W | Fields skipped after the start event |
| cfg_count | input | CNT_W | Number of fields or frames to capture |
| cfg_frame_mode | input | 1 | 1 = count frames of two fields |
| cfg_align_en | input | 1 | Enable start-parity alignment in frame mode |
| cfg_align_odd | input | 1 | Wanted parity of the first captured field |
| sw_start | input | 1 | Software start pulse |
| sw_arm | input | 1 | Software arm pulse, wait for a trigger |
| sw_abort | input | 1 | Software abort pulse |
| cap_en | output | 1 | Capture enable, field aligned |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| cap_count | output | CNT_W | Units captured so far |

## Verification
A sequencer stuck in the wrong state shows up within one field period. It appears as a capture enable that opens one field early or late, or that stays shut, or as `busy` and `done` disagreeing with the enable. A miscounting field counter gives the wrong number of enabled fields. It also leaves a `cap_count` that differs from the programmed count at the moment `done` rises. A broken edge path shows up before the first field as a start that never comes, or as one caused by a disabled line or by the wrong edge.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ARMED  = 3'd1,
      ST_DELAY  = 3'd2,
      ST_PARITY = 3'd3,
      ST_CAPT   = 3'd4,
      ST_DONE   = 3'd5
   } seq_state_t;
endpackage

// File: rtl/vsc_trig_detect.sv
module vsc_trig_detect #(
   parameter int NTRIG       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_HIT     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTRIG-1:0] trig_in,
   input  logic [NTRIG-1:0] line_en,
   input  logic [NTRIG-1:0] line_fall,
   output logic             hit
);
   logic [NTRIG-1:0] line_edge;
   logic             any_edge;

   if (NTRIG < 1) begin : g_bad_ntrig
      $error("NTRIG must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < NTRIG; i++) begin : g_line
      logic [SYNC_STAGES:0] shreg;
      logic                 now_lvl, old_lvl;
      always_ff @(posedge clk) begin
         if (!rst_n) shreg <= '0;
         else        shreg <= {shreg[SYNC_STAGES-1:0], trig_in[i]};
      end
      assign now_lvl = shreg[SYNC_STAGES-1];
      assign old_lvl = shreg[SYNC_STAGES];
      assign line_edge[i] = line_en[i] &
                            (line_fall[i] ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl));
   end

   assign any_edge = |line_edge;

   if (REG_HIT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) hit <= 1'b0;
         else        hit <= any_edge;
      end
   end else begin : g_comb
      assign hit = any_edge;
   end
endmodule

// File: rtl/vsc_sequencer.sv
module vsc_sequencer
   import vsc_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             field_start,
   input  logic             field_odd,
   input  logic             trig_hit,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             cfg_frame_mode,
   input  logic             cfg_align_en,
   input  logic             cfg_align_odd,
   input  logic             sw_start,
   input  logic             sw_arm,
   input  logic             sw_abort,
   output logic             cap_en,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] cap_count
);
   localparam int FW = CNT_W + 1;

   seq_state_t       state;
   logic [DLY_W-1:0] dly_cnt;
   logic [FW-1:0]    fld_cnt;
   logic [FW-1:0]    target;
   logic [CNT_W-1:0] eff_count;
   logic             par_ok;
   logic             delay_zero;

   if (CNT_W < 1 || DLY_W < 1) begin : g_bad_w
      $error("CNT_W and DLY_W must be at least 1");
   end

   assign eff_count  = (cfg_count == '0) ? CNT_W'(1) : cfg_count;
   assign target     = cfg_frame_mode ? {eff_count, 1'b0} : {1'b0, eff_count};
   assign par_ok     = !(cfg_frame_mode && cfg_align_en) || (field_odd == cfg_align_odd);
   assign delay_zero = (cfg_delay == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || sw_abort) begin
         state   <= ST_IDLE;
         dly_cnt <= '0;
         fld_cnt <= '0;
         cap_en  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (sw_start) begin
                  fld_cnt <= '0;
                  dly_cnt <= '0;
                  state   <= delay_zero ? ST_PARITY : ST_DELAY;
               end else if (sw_arm) begin
                  fld_cnt <= '0;
                  state   <= ST_ARMED;
               end
            end
            ST_ARMED: begin
               if (sw_start || trig_hit) begin
                  dly_cnt <= '0;
                  state   <= delay_zero ? ST_PARITY : ST_DELAY;
               end
            end
            ST_DELAY: begin
               if (field_start) begin
                  if (dly_cnt == cfg_delay - 1'b1) state <= ST_PARITY;
                  else                             dly_cnt <= dly_cnt + 1'b1;
               end
            end
            ST_PARITY: begin
               if (field_start && par_ok) begin
                  cap_en <= 1'b1;
                  state  <= ST_CAPT;
               end
            end
            ST_CAPT: begin
               if (field_start) begin
                  fld_cnt <= fld_cnt + 1'b1;
                  if (fld_cnt + 1'b1 == target) begin
                     cap_en <= 1'b0;
                     state  <= ST_DONE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE) && (state != ST_DONE);
   assign done      = (state == ST_DONE);
   assign cap_count = cfg_frame_mode ? fld_cnt[FW-1:1] : fld_cnt[CNT_W-1:0];
endmodule

// File: rtl/vid_start_ctrl.sv
module vid_start_ctrl #(
   parameter int NTRIG       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_HIT     = 1'b0,
   parameter int CNT_W       = 4,
   parameter int DLY_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             field_start,
   input  logic             field_odd,
   input  logic [NTRIG-1:0] trig_in,
   input  logic [NTRIG-1:0] cfg_trig_en,
   input  logic [NTRIG-1:0] cfg_trig_fall,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             cfg_frame_mode,
   input  logic             cfg_align_en,
   input  logic             cfg_align_odd,
   input  logic             sw_start,
   input  logic             sw_arm,
   input  logic             sw_abort,
   output logic             cap_en,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] cap_count
);
   logic trig_hit;

   vsc_trig_detect #(
      .NTRIG(NTRIG), .SYNC_STAGES(SYNC_STAGES), .REG_HIT(REG_HIT)
   ) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
      .line_en(cfg_trig_en), .line_fall(cfg_trig_fall), .hit(trig_hit)
   );

   vsc_sequencer #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .field_start(field_start), .field_odd(field_odd),
      .trig_hit(trig_hit), .cfg_delay(cfg_delay), .cfg_count(cfg_count),
      .cfg_frame_mode(cfg_frame_mode), .cfg_align_en(cfg_align_en),
      .cfg_align_odd(cfg_align_odd), .sw_start(sw_start), .sw_arm(sw_arm),
      .sw_abort(sw_abort), .cap_en(cap_en), .busy(busy), .done(done),
      .cap_count(cap_count)
   );
endmodule

// File: rtl/vsc_checker.sv
module vsc_checker #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             field_start,
   input logic             sw_abort,
   input logic [CNT_W-1:0] cfg_count,
   input logic             cap_en,
   input logic             busy,
   input logic             done,
   input logic [CNT_W-1:0] cap_count
);
   logic [CNT_W-1:0] eff;
   assign eff = (cfg_count == '0) ? CNT_W'(1) : cfg_count;

   // R9
   cap_edge_on_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en != $past(cap_en)) |-> ($past(field_start) || $past(sw_abort)));

   // R11
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R11
   cap_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> busy);

   // R3
   final_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (cap_count == eff));

   // R10
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_abort |=> (!busy && !done && !cap_en && cap_count == '0));
endmodule

bind vid_start_ctrl vsc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .field_start(field_start), .sw_abort(sw_abort),
   .cfg_count(cfg_count), .cap_en(cap_en), .busy(busy), .done(done),
   .cap_count(cap_count)
);

// File: tb/vid_start_ctrl_test.sv
`timescale 1ns/1ps
module vid_start_ctrl_test;
   localparam int NT = 4;
   localparam int CW = 4;
   localparam int DW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic field_start = 1'b0, field_odd = 1'b0;
   logic [NT-1:0] trig_in = '0, cfg_trig_en = '0, cfg_trig_fall = '0;
   logic [DW-1:0] cfg_delay = '0;
   logic [CW-1:0] cfg_count = '0;
   logic cfg_frame_mode = 1'b0, cfg_align_en = 1'b0, cfg_align_odd = 1'b0;
   logic sw_start = 1'b0, sw_arm = 1'b0, sw_abort = 1'b0;
   logic cap_en, busy, done;
   logic [CW-1:0] cap_count;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   vid_start_ctrl #(.NTRIG(NT), .CNT_W(CW), .DLY_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .field_start(field_start), .field_odd(field_odd),
      .trig_in(trig_in), .cfg_trig_en(cfg_trig_en), .cfg_trig_fall(cfg_trig_fall),
      .cfg_delay(cfg_delay), .cfg_count(cfg_count), .cfg_frame_mode(cfg_frame_mode),
      .cfg_align_en(cfg_align_en), .cfg_align_odd(cfg_align_odd),
      .sw_start(sw_start), .sw_arm(sw_arm), .sw_abort(sw_abort),
      .cap_en(cap_en), .busy(busy), .done(done), .cap_count(cap_count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff_count(input int c);
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int exp_first(input int dly, input bit frame, input bit al_en,
                                    input bit al_odd, input bit p0);
      int f = dly;
      if (frame && al_en && ((p0 ^ f[0]) != al_odd)) f++;
      return f;
   endfunction

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   task automatic do_field(input bit odd, output bit ce);
      @(negedge clk);
      field_start = 1'b1;
      field_odd   = odd;
      @(negedge clk);
      field_start = 1'b0;
      ce = cap_en;
      repeat (3) @(negedge clk);
      check(cap_en == ce, "R9 cap_en moved inside a field", cap_en, ce);
   endtask

   task automatic run_acq(input bit frame, input int cnt, input int dly, input bit al_en,
                          input bit al_odd, input bit use_trig, input int line,
                          input bit fall, input bit p0, input bit poke);
      int  nf, first, seen, ncap;
      bit  ce, par1;
      int  other;
      cfg_frame_mode = frame;
      cfg_count      = CW'(cnt);
      cfg_delay      = DW'(dly);
      cfg_align_en   = al_en;
      cfg_align_odd  = al_odd;
      cfg_trig_en    = use_trig ? NT'(1 << line) : '0;
      cfg_trig_fall  = NT'(fall) << line;
      trig_in        = fall ? NT'(1 << line) : '0;
      repeat (6) @(negedge clk);
      if (use_trig) begin
         pulse(sw_arm);
         @(negedge clk);
         check(busy == 1'b1, "R11 busy while armed", busy, 1);
         do_field(!p0, ce);
         check(ce == 1'b0, "R4 armed must not capture", ce, 0);
         other = (line + 1) % NT;
         trig_in[other] = ~trig_in[other];
         repeat (6) @(negedge clk);
         do_field(!p0, ce);
         check(ce == 1'b0, "R4 disabled line ignored", ce, 0);
         trig_in[line] = ~trig_in[line];
         repeat (6) @(negedge clk);
      end else begin
         pulse(sw_start);
         @(negedge clk);
      end
      nf    = eff_count(cnt) * (frame ? 2 : 1);
      first = exp_first(dly, frame, al_en, al_odd, p0);
      seen  = -1;
      ncap  = 0;
      par1  = 1'b0;
      for (int i = 0; i < first + nf + 2; i++) begin
         do_field(p0 ^ i[0], ce);
         if (ce) begin
            if (seen < 0) begin
               seen = i;
               par1 = p0 ^ i[0];
               if (poke && nf > 1) begin
                  pulse(sw_start);
                  trig_in = ~trig_in;
               end
            end
            ncap++;
         end
      end
      check(seen == first, use_trig ? (fall ? "R5 R6 start field" : "R4 R6 start field")
                                    : "R2 R6 start field", seen, first);
      check(ncap == nf, poke ? "R8 R3 captured fields" : "R3 captured fields", ncap, nf);
      if (frame && al_en)
         check(par1 == al_odd, "R7 first field parity", par1, al_odd);
      check(done == 1'b1 && busy == 1'b0, "R11 done after sequence", {done, busy}, 2);
      check(int'(cap_count) == eff_count(cnt), "R3 cap_count", cap_count, eff_count(cnt));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      bit ce;
      void'($urandom(32'd99));
      repeat (4) @(negedge clk);
      check(cap_en == 0 && busy == 0 && done == 0 && cap_count == 0,
            "R1 reset state", {cap_en, busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cap_en == 0 && busy == 0 && done == 0 && cap_count == 0,
            "R1 after reset release", {cap_en, busy, done}, 0);

      // directed corners
      run_acq(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);  // R2 single-field snap
      run_acq(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);  // R3 zero count acts as one
      run_acq(1, 3, 2, 1, 1, 0, 0, 0, 0, 0);  // R7 odd alignment after delay
      run_acq(1, 2, 0, 1, 0, 0, 0, 0, 1, 0);  // R7 even alignment
      run_acq(0, 2, 1, 1, 1, 0, 0, 0, 0, 0);  // R7 field mode ignores alignment
      run_acq(0, 3, 0, 0, 0, 1, 2, 0, 0, 1);  // R4 rising trigger, R8 poke
      run_acq(1, 2, 1, 0, 0, 1, 1, 1, 1, 1);  // R5 falling trigger, R8 poke

      // R10 abort during capture
      cfg_frame_mode = 0; cfg_count = 4'd5; cfg_delay = '0; cfg_align_en = 0;
      pulse(sw_start);
      do_field(1'b0, ce);
      check(ce == 1'b1, "R2 capture opened", ce, 1);
      pulse(sw_abort);
      check(!busy && !done && !cap_en && cap_count == 0, "R10 abort in capture",
            {busy, done, cap_en}, 0);

      // R10 abort while armed, later edge ignored
      cfg_trig_en = 4'b0001; cfg_trig_fall = '0; trig_in = '0;
      repeat (4) @(negedge clk);
      pulse(sw_arm);
      pulse(sw_abort);
      trig_in[0] = 1'b1;
      repeat (6) @(negedge clk);
      do_field(1'b1, ce);
      check(!busy && !ce, "R10 idle ignores trigger", {busy, ce}, 0);

      // constrained random
      for (int k = 0; k < 24; k++) begin
         bit fr, ae, ao, ut, fa, p, pk;
         int c, d, ln;
         fr = $urandom_range(1, 0);
         c  = $urandom_range(4, 0);
         d  = $urandom_range(3, 0);
         ae = $urandom_range(1, 0);
         ao = $urandom_range(1, 0);
         ut = $urandom_range(1, 0);
         ln = $urandom_range(NT - 1, 0);
         fa = $urandom_range(1, 0);
         p  = $urandom_range(1, 0);
         pk = $urandom_range(1, 0);
         run_acq(fr, c, d, ae, ao, ut, ln, fa, p, pk);
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule